// File: doc/BRIEF.md
# Line Presence Filter (Split Counting Bloom Filter)

This block keeps an approximate record of which physical line addresses are currently held in a cache. The cache controller reports every linefill as an allocate event and every line it drops as an evict event. Any other agent can ask whether a line address might be cached. A query answer of 0 proves that the line is absent, so the asker can skip an expensive search, such as a serial probe of every set that could hold an alias. An answer of 1 means the line may be present.

The structure is split in two. A bank of small saturating counters follows the allocate and evict traffic. A one-bit-per-index presence vector serves the queries. Each side computes its index with its own copy of the same XOR-folding hash. A counter writes the presence vector only when it moves from zero to nonzero or from nonzero to zero. Each update therefore writes at most one vector bit, and queries never read the counters.

Top module: `line_presence_filter`

## Requirements
- R1: The index is the bitwise XOR of the line address cut into consecutive IDX_W-bit chunks. Chunk 0 is bits [IDX_W-1:0], chunk 1 is the next IDX_W bits, and so on. The top chunk is padded with zeros above bit ADDR_W-1. Two addresses that fold to the same index share one counter and one presence bit.
- R2: After reset every counter and every presence bit is 0, and `qry_done`, `qry_hit` and `upd_underflow` are 0.
- R3: An allocate (`upd_valid`=1, `upd_alloc`=1) to an index whose counter is 0 sets that index's presence bit. The change is seen by queries issued two or more cycles after the update.
- R4: Each allocate increments the indexed counter and each evict (`upd_alloc`=0) decrements it. The presence bit stays 1 while the counter is nonzero and is cleared by the evict that brings the counter to 0.
- R5: `qry_done` is 1 exactly in the cycle after a cycle with `qry_valid`=1. In that cycle, `qry_hit` carries the presence bit of the queried index.
- R6: A query issued in the same cycle as an update to the same index, or in the cycle right after it, returns the presence bit as it was before that update.
- R7: A counter at its maximum value (2^CNT_W-1) ignores further allocates and does not wrap.
- R8: An evict to a counter at 0 leaves the counter and the presence bit unchanged, and raises `upd_underflow` for one cycle, in the cycle after the evict.
- R9: Presence bits are written only when a counter crosses zero. Updates to one index never change the query result of another index.
- R10: With `upd_valid`=0, the `upd_alloc` and `upd_addr` inputs change no counter and no presence bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_valid | input | 1 | Update event present |
| upd_alloc | input | 1 | 1 = line allocated, 0 = line evicted |
| upd_addr | input | ADDR_W | Physical line address of the update |
| upd_underflow | output | 1 | Registered: the previous update was an evict of a zero counter |
| qry_valid | input | 1 | Membership query present |
| qry_addr | input | ADDR_W | Physical line address queried |
| qry_done | output | 1 | Registered: query result valid this cycle |
| qry_hit | output | 1 | Registered: 0 = absent for certain, 1 = possibly present |

## Verification
The assertions check the following on every cycle:
- the two hash copies agree whenever both ports carry the same address;
- `qry_done` follows `qry_valid` by exactly one cycle;
- `upd_underflow` never appears without an evict in the cycle before;
- the presence vector is written only in the cycle after a valid update;
- nothing is reported in the cycle after reset.

Only the bench scenarios can show the counting behaviour: sharing through hash aliases, the bit surviving partial evicts, saturation and the evict count it takes to come back down from it, the read-before-update result on a collision, and the isolation of neighbouring indices.

// File: rtl/lpf_pkg.sv
package lpf_pkg;
  // Number of IDX_W-wide chunks needed to cover an ADDR_W-wide address.
  function automatic int chunk_count(input int addr_w, input int idx_w);
    return (addr_w + idx_w - 1) / idx_w;
  endfunction

  typedef enum logic {
    EV_EVICT = 1'b0,
    EV_ALLOC = 1'b1
  } upd_kind_e;
endpackage

// File: rtl/lpf_fold_hash.sv
module lpf_fold_hash #(
  parameter int ADDR_W = 26,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam int NCH   = lpf_pkg::chunk_count(ADDR_W, IDX_W);
  localparam int PAD_W = NCH * IDX_W;

  logic [PAD_W-1:0] padded;
  logic [IDX_W-1:0] acc [NCH];

  always_comb begin
    padded = '0;
    padded[ADDR_W-1:0] = addr;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_fold
    if (g == 0) begin : g_first
      assign acc[g] = padded[IDX_W-1:0];
    end else begin : g_rest
      assign acc[g] = acc[g-1] ^ padded[g*IDX_W +: IDX_W];
    end
  end

  assign idx = acc[NCH-1];
endmodule

// File: rtl/lpf_counter_bank.sv
module lpf_counter_bank #(
  parameter int IDX_W = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             inc,
  input  logic [IDX_W-1:0] idx,
  output logic             cross_we,
  output logic [IDX_W-1:0] cross_idx,
  output logic             cross_val,
  output logic             underflow
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt [DEPTH];
  logic [CNT_W-1:0] cur;
  logic             at_zero, at_max, at_one;

  assign cur     = cnt[idx];
  assign at_zero = (cur == '0);
  assign at_max  = (cur == CNT_MAX);
  assign at_one  = (cur == CNT_ONE);

  // Counter storage: read-modify-write in one cycle, saturating both ways.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) cnt[i] <= '0;
    end else if (en) begin
      if (inc && !at_max)       cnt[idx] <= cur + CNT_ONE;
      else if (!inc && !at_zero) cnt[idx] <= cur - CNT_ONE;
    end
  end

  // Zero-boundary detector: uses the pre-update value and the direction.
  always_ff @(posedge clk) begin
    if (rst) begin
      cross_we  <= 1'b0;
      cross_idx <= '0;
      cross_val <= 1'b0;
      underflow <= 1'b0;
    end else begin
      cross_we  <= en && ((inc && at_zero) || (!inc && at_one));
      cross_idx <= idx;
      cross_val <= inc;
      underflow <= en && !inc && at_zero;
    end
  end
endmodule

// File: rtl/lpf_presence_vec.sv
module lpf_presence_vec #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic             wval,
  input  logic             re,
  input  logic [IDX_W-1:0] ridx,
  output logic             rbit
);
  localparam int DEPTH = 1 << IDX_W;

  logic mem [DEPTH];

  // One write port, one registered read port; read returns the old bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 1'b0;
      rbit <= 1'b0;
    end else begin
      if (we) mem[widx] <= wval;
      if (re) rbit <= mem[ridx];
    end
  end
endmodule

// File: rtl/line_presence_filter.sv
module line_presence_filter #(
  parameter int ADDR_W = 26,
  parameter int IDX_W  = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_valid,
  input  logic              upd_alloc,
  input  logic [ADDR_W-1:0] upd_addr,
  output logic              upd_underflow,
  input  logic              qry_valid,
  input  logic [ADDR_W-1:0] qry_addr,
  output logic              qry_done,
  output logic              qry_hit
);
  logic [IDX_W-1:0] upd_idx, qry_idx, vec_widx;
  logic             vec_we, vec_wval;

  // Counter-side hash copy
  lpf_fold_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_upd (
    .addr(upd_addr), .idx(upd_idx)
  );

  // Vector-side hash copy
  lpf_fold_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash_qry (
    .addr(qry_addr), .idx(qry_idx)
  );

  lpf_counter_bank #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst),
    .en(upd_valid),
    .inc(upd_alloc == lpf_pkg::EV_ALLOC),
    .idx(upd_idx),
    .cross_we(vec_we), .cross_idx(vec_widx), .cross_val(vec_wval),
    .underflow(upd_underflow)
  );

  lpf_presence_vec #(.IDX_W(IDX_W)) u_vec (
    .clk(clk), .rst(rst),
    .we(vec_we), .widx(vec_widx), .wval(vec_wval),
    .re(qry_valid), .ridx(qry_idx), .rbit(qry_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) qry_done <= 1'b0;
    else     qry_done <= qry_valid;
  end
endmodule

// File: rtl/lpf_checker.sv
module lpf_checker #(
  parameter int ADDR_W = 26,
  parameter int IDX_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              upd_valid,
  input logic              upd_alloc,
  input logic [ADDR_W-1:0] upd_addr,
  input logic              upd_underflow,
  input logic              qry_valid,
  input logic [ADDR_W-1:0] qry_addr,
  input logic              qry_done,
  input logic [IDX_W-1:0]  upd_idx,
  input logic [IDX_W-1:0]  qry_idx,
  input logic              vec_we
);
  // R1
  hash_agree_chk: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && qry_valid && upd_addr == qry_addr) |-> (upd_idx == qry_idx));

  // R5
  qry_done_chk: assert property (@(posedge clk) disable iff (rst)
    qry_valid |=> qry_done);

  // R5
  qry_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !qry_valid |=> !qry_done);

  // R8
  underflow_src_chk: assert property (@(posedge clk) disable iff (rst)
    upd_underflow |-> $past(upd_valid && !upd_alloc));

  // R9
  vec_write_src_chk: assert property (@(posedge clk) disable iff (rst)
    vec_we |-> $past(upd_valid));

  // R2
  post_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(!rst) |-> (!qry_done && !upd_underflow));
endmodule

bind line_presence_filter lpf_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lpf_chk (
  .clk(clk), .rst(rst),
  .upd_valid(upd_valid), .upd_alloc(upd_alloc), .upd_addr(upd_addr),
  .upd_underflow(upd_underflow),
  .qry_valid(qry_valid), .qry_addr(qry_addr), .qry_done(qry_done),
  .upd_idx(upd_idx), .qry_idx(qry_idx), .vec_we(vec_we)
);

// File: tb/test_line_presence_filter.sv
module test_line_presence_filter;
  localparam int ADDR_W = 26;
  localparam int IDX_W  = 8;
  localparam int CNT_W  = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_valid = 1'b0, upd_alloc = 1'b0;
  logic [ADDR_W-1:0] upd_addr = '0, qry_addr = '0;
  logic qry_valid = 1'b0;
  logic upd_underflow, qry_done, qry_hit;

  int n_run = 0, n_fail = 0;
  logic last_uf;
  logic last_hit, last_done;

  always #5 clk = ~clk;

  line_presence_filter #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_line_presence_filter (
    .clk(clk), .rst(rst),
    .upd_valid(upd_valid), .upd_alloc(upd_alloc), .upd_addr(upd_addr),
    .upd_underflow(upd_underflow),
    .qry_valid(qry_valid), .qry_addr(qry_addr),
    .qry_done(qry_done), .qry_hit(qry_hit)
  );

  function automatic logic [IDX_W-1:0] tb_hash(input logic [ADDR_W-1:0] a);
    logic [IDX_W-1:0] h = '0;
    for (int b = 0; b < ADDR_W; b++) h[b % IDX_W] = h[b % IDX_W] ^ a[b];
    return h;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // Update, then one idle cycle so later queries see its effect.
  task automatic do_upd(input logic alloc, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    upd_valid = 1'b1; upd_alloc = alloc; upd_addr = a;
    @(negedge clk);
    last_uf = upd_underflow;
    upd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_qry(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    qry_valid = 1'b1; qry_addr = a;
    @(negedge clk);
    last_done = qry_done; last_hit = qry_hit;
    qry_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R2 done", qry_done, 1'b0);
    check("R2 uf", upd_underflow, 1'b0);
    do_qry(26'h0); check("R2 empty idx0", last_hit, 1'b0);
    do_qry(26'h3ff_ffff); check("R2 empty high", last_hit, 1'b0);
  endtask

  task automatic t_alloc_alias;
    do_upd(1'b1, 26'h1);
    do_qry(26'h1);
    check("R5 done", last_done, 1'b1);
    check("R3 hit after alloc", last_hit, 1'b1);
    check("R1 alias hash", tb_hash(26'h100) == tb_hash(26'h1), 1'b1);
    do_qry(26'h100); check("R1 alias chunk1", last_hit, 1'b1);
    do_qry(26'h100_0000); check("R1 alias padded top chunk", last_hit, 1'b1);
    do_qry(26'h2); check("R9 neighbour idx", last_hit, 1'b0);
    @(negedge clk); check("R5 idle done", qry_done, 1'b0);
  endtask

  task automatic t_multi;
    do_upd(1'b1, 26'h100);        // counter for idx 1 now 2
    do_upd(1'b1, 26'h5);
    do_upd(1'b0, 26'h1);          // idx 1 -> 1
    do_qry(26'h1); check("R4 partial evict keeps bit", last_hit, 1'b1);
    do_upd(1'b0, 26'h100_0000);   // idx 1 -> 0
    do_qry(26'h1); check("R4 last evict clears", last_hit, 1'b0);
    do_qry(26'h5); check("R9 other idx unaffected", last_hit, 1'b1);
    do_upd(1'b0, 26'h5);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    upd_valid = 1'b1; upd_alloc = 1'b1; upd_addr = 26'h7;
    qry_valid = 1'b1; qry_addr = 26'h7;
    @(negedge clk);
    check("R6 same-cycle old value", qry_hit, 1'b0);
    upd_valid = 1'b0;              // query again the very next cycle
    @(negedge clk);
    check("R6 next-cycle old value", qry_hit, 1'b0);
    qry_valid = 1'b0;
    do_qry(26'h7); check("R6 later sees update", last_hit, 1'b1);
    do_upd(1'b0, 26'h7);
  endtask

  task automatic t_saturate;
    for (int i = 0; i < CMAX + 2; i++) do_upd(1'b1, 26'h9);
    for (int i = 0; i < CMAX - 1; i++) do_upd(1'b0, 26'h9);
    do_qry(26'h9); check("R7 still set before max evicts", last_hit, 1'b1);
    do_upd(1'b0, 26'h9);
    check("R7 no underflow at 1->0", last_uf, 1'b0);
    do_qry(26'h9); check("R7 saturated count clears after max evicts", last_hit, 1'b0);
  endtask

  task automatic t_underflow;
    do_upd(1'b0, 26'h9);
    check("R8 underflow flagged", last_uf, 1'b1);
    @(negedge clk); check("R8 flag one cycle", upd_underflow, 1'b0);
    do_qry(26'h9); check("R8 bit stays 0", last_hit, 1'b0);
    do_upd(1'b1, 26'h9);
    do_qry(26'h9); check("R8 counter stayed 0 (alloc sets)", last_hit, 1'b1);
    do_upd(1'b0, 26'h9);
    do_qry(26'h9); check("R8 single evict clears", last_hit, 1'b0);
  endtask

  task automatic t_invalid;
    @(negedge clk);
    upd_valid = 1'b0; upd_alloc = 1'b1; upd_addr = 26'hb;
    repeat (3) @(negedge clk);
    upd_alloc = 1'b0;
    do_qry(26'hb); check("R10 no update when invalid", last_hit, 1'b0);
    do_upd(1'b0, 26'hb);
    check("R10 counter untouched (underflow)", last_uf, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_alloc_alias();
    t_multi();
    t_same_cycle();
    t_saturate();
    t_underflow();
    t_invalid();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule